// File: doc/BRIEF.md
# Dual-Compare Free-Running Timer

A 16-bit up-counter advances by one on every clock and is compared against two 16-bit match registers. A match against the first register (channel A) or the second (channel B), and a wrap of the counter from its top value back to zero, each set a sticky flag. Channel A can also restart the counter from zero instead of letting it advance. Each flag has its own enable, and a single interrupt request carries a vector number that identifies the highest-priority enabled flag.

Software reaches the timer over a byte-wide register bus with eight byte addresses. Reads are combinational and writes take effect at the clock edge. Word registers are big-endian: the high byte is at the lower address. Both match registers share one word address. A select bit in the output-control byte decides which of the two that address reads and writes. Prescaling, capture inputs, output pins and interrupt acknowledge are handled elsewhere.

Top module: `frc_timer`

## Requirements
- R1: While `rst` is high the counter, all flags, the clear-on-A bit, the enables and the select bit go to 0. Both match registers go to 0xFFFF. After reset `irq` is 0 and `irq_vector` is 0.
- R2: On any edge with no counter-byte write and no channel-A restart, the counter advances by exactly 1. It reads big-endian, with the high byte at address 2 and the low byte at address 3.
- R3: A write to address 2 or 3 replaces only that byte of the counter. On that edge the counter does not advance and no compare or wrap event is taken.
- R4: The match word at addresses 4 (high) and 5 (low) reads and writes channel A when bit 4 of output-control (address 7) is 0, and channel B when it is 1.
- R5: On an edge where the counter equals match A, bit 3 of the status byte (address 1) sets. If the clear-on-A bit (status bit 0) is 1, the counter loads 0 instead of advancing.
- R6: On an edge where the counter equals match B, status bit 2 sets. Channel B never restarts the counter.
- R7: When the counter advances from 0xFFFF to 0, status bit 1 sets. A channel-A restart taken at 0xFFFF does not set it.
- R8: Flags are sticky. A status write with a 0 in a flag bit clears that flag, and a 1 leaves it as it was. A set event on the same edge as a clearing write wins. Status bit 0 stores the written value.
- R9: `irq` is high exactly while some flag is set whose enable is also set. The enables are at address 0: bit 3 for channel A, bit 2 for channel B, bit 1 for wrap.
- R10: `irq_vector` is 18 when the wrap request is active, otherwise 17 for channel B, otherwise 16 for channel A, and 0 when no request is active.
- R11: Unused bits read 0. The enable byte keeps bits 3..1 only, output-control keeps bit 4 only, and address 6 always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request, high while an enabled flag is set |
| irq_vector | output | 8 | Vector of the highest-priority active request, 0 when idle |

## Verification
The bench builds the timer with its default 16-bit counter and 8-bit vector. Counter-byte writes let it jump straight to points just before a match or just before 0xFFFF, so matches, restarts and wraps are reached within tens of cycles instead of a full 65536-cycle period. It sweeps all eight enable combinations against four flag states and checks every request level and vector. It also covers the restart-at-0xFFFF case and the case where a flag sets on the same edge as a clearing write.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int VEC_W  = 8;
    localparam int NUM_CMP = 2;

    // register byte addresses
    localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RSVD    = 3'd6;
    localparam logic [ADDR_W-1:0] A_OUTCTL  = 3'd7;

    // bit positions (shared by enable and status bytes)
    localparam int B_CHA   = 3;
    localparam int B_CHB   = 2;
    localparam int B_WRAP  = 1;
    localparam int B_CLRA  = 0;
    localparam int B_SEL   = 4;

    // vector numbers
    localparam logic [VEC_W-1:0] V_NONE = 8'd0;
    localparam logic [VEC_W-1:0] V_CHA  = 8'd16;
    localparam logic [VEC_W-1:0] V_CHB  = 8'd17;
    localparam logic [VEC_W-1:0] V_WRAP = 8'd18;

    typedef struct packed {
        logic cha;
        logic chb;
        logic wrap;
    } evt_t;

    typedef logic [CNT_W-1:0] cnt_t;

    // place the three flag-type bits at their byte positions
    function automatic logic [BYTE_W-1:0] evt_to_byte(input evt_t e);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[B_CHA]  = e.cha;
        b[B_CHB]  = e.chb;
        b[B_WRAP] = e.wrap;
        return b;
    endfunction

    function automatic evt_t byte_to_evt(input logic [BYTE_W-1:0] b);
        evt_t e;
        e.cha  = b[B_CHA];
        e.chb  = b[B_CHB];
        e.wrap = b[B_WRAP];
        return e;
    endfunction

    // fixed priority: wrap over channel B over channel A
    function automatic logic [VEC_W-1:0] pick_vector(input evt_t p);
        if (p.wrap)     return V_WRAP;
        else if (p.chb) return V_CHB;
        else if (p.cha) return V_CHA;
        else            return V_NONE;
    endfunction

endpackage

// File: rtl/frc_counter.sv
module frc_counter
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [BYTE_W-1:0] ld_byte,
    input  cnt_t              cmp_a,
    input  cnt_t              cmp_b,
    input  logic              clr_on_a,
    output cnt_t              count,
    output evt_t              evt
);

    localparam cnt_t TOP = {CNT_W{1'b1}};

    cnt_t cnt_q;
    logic running;
    logic restart;

    always_comb begin
        running  = !(ld_hi || ld_lo);
        evt.cha  = running && (cnt_q == cmp_a);
        evt.chb  = running && (cnt_q == cmp_b);
        restart  = evt.cha && clr_on_a;
        evt.wrap = running && !restart && (cnt_q == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_hi) begin
            cnt_q[CNT_W-1:BYTE_W] <= ld_byte;
        end else if (ld_lo) begin
            cnt_q[BYTE_W-1:0] <= ld_byte;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/frc_regbank.sv
module frc_regbank
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  cnt_t              count,
    input  evt_t              evt,
    output logic [BYTE_W-1:0] bus_rdata,
    output cnt_t              cmp_a,
    output cnt_t              cmp_b,
    output logic              clr_on_a,
    output evt_t              flags,
    output evt_t              enables
);

    cnt_t  cmp_q [NUM_CMP];
    logic  sel_q;
    logic  clr_q;
    evt_t  flag_q;
    evt_t  en_q;
    evt_t  keep;
    logic  wr_stat;
    logic  wr_en;
    logic  wr_sel;

    assign wr_stat = bus_wr && (bus_addr == A_STATUS);
    assign wr_en   = bus_wr && (bus_addr == A_ENABLE);
    assign wr_sel  = bus_wr && (bus_addr == A_OUTCTL);

    // one match register per channel; the shared address reaches one of them
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        logic hit_hi;
        logic hit_lo;
        assign hit_hi = bus_wr && (bus_addr == A_CMP_HI) && (sel_q == g[0]);
        assign hit_lo = bus_wr && (bus_addr == A_CMP_LO) && (sel_q == g[0]);
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[g] <= {CNT_W{1'b1}};
            end else if (hit_hi) begin
                cmp_q[g][CNT_W-1:BYTE_W] <= bus_wdata;
            end else if (hit_lo) begin
                cmp_q[g][BYTE_W-1:0] <= bus_wdata;
            end
        end
    end

    always_comb begin
        keep = wr_stat ? byte_to_evt(bus_wdata) : 3'b111;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            clr_q  <= 1'b0;
            en_q   <= '0;
            sel_q  <= 1'b0;
        end else begin
            flag_q <= (flag_q & keep) | evt;
            if (wr_stat) clr_q <= bus_wdata[B_CLRA];
            if (wr_en)   en_q  <= byte_to_evt(bus_wdata);
            if (wr_sel)  sel_q <= bus_wdata[B_SEL];
        end
    end

    always_comb begin
        cnt_t cmp_sel;
        cmp_sel   = cmp_q[sel_q];
        bus_rdata = '0;
        unique case (bus_addr)
            A_ENABLE: bus_rdata = evt_to_byte(en_q);
            A_STATUS: begin
                bus_rdata         = evt_to_byte(flag_q);
                bus_rdata[B_CLRA] = clr_q;
            end
            A_CNT_HI: bus_rdata = count[CNT_W-1:BYTE_W];
            A_CNT_LO: bus_rdata = count[BYTE_W-1:0];
            A_CMP_HI: bus_rdata = cmp_sel[CNT_W-1:BYTE_W];
            A_CMP_LO: bus_rdata = cmp_sel[BYTE_W-1:0];
            A_RSVD:   bus_rdata = '0;
            A_OUTCTL: bus_rdata[B_SEL] = sel_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign cmp_a    = cmp_q[0];
    assign cmp_b    = cmp_q[1];
    assign clr_on_a = clr_q;
    assign flags    = flag_q;
    assign enables  = en_q;

endmodule

// File: rtl/frc_irq_sel.sv
module frc_irq_sel
    import frc_pkg::*;
(
    input  evt_t             flags,
    input  evt_t             enables,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vector
);

    evt_t pend;

    always_comb begin
        pend       = flags & enables;
        irq        = |pend;
        irq_vector = pick_vector(pend);
    end

endmodule

// File: rtl/frc_timer.sv
module frc_timer
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    output logic [VEC_W-1:0]  irq_vector
);

    cnt_t count;
    cnt_t cmp_a;
    cnt_t cmp_b;
    evt_t evt;
    evt_t flags;
    evt_t enables;
    logic clr_on_a;
    logic ld_hi;
    logic ld_lo;

    assign ld_hi = bus_wr && (bus_addr == A_CNT_HI);
    assign ld_lo = bus_wr && (bus_addr == A_CNT_LO);

    frc_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .ld_hi    (ld_hi),
        .ld_lo    (ld_lo),
        .ld_byte  (bus_wdata),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .clr_on_a (clr_on_a),
        .count    (count),
        .evt      (evt)
    );

    frc_regbank u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .count     (count),
        .evt       (evt),
        .bus_rdata (bus_rdata),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .clr_on_a  (clr_on_a),
        .flags     (flags),
        .enables   (enables)
    );

    frc_irq_sel u_irq (
        .flags      (flags),
        .enables    (enables),
        .irq        (irq),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/frc_timer_checker.sv
module frc_timer_checker
    import frc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              irq,
    input logic [VEC_W-1:0]  irq_vector,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cmp_a,
    input logic [CNT_W-1:0]  cmp_b,
    input logic              clr_on_a,
    input logic [2:0]        flags
);

    logic cnt_ld;
    logic stat_wr;
    logic a_restart;

    assign cnt_ld    = bus_wr && ((bus_addr == A_CNT_HI) || (bus_addr == A_CNT_LO));
    assign stat_wr   = bus_wr && (bus_addr == A_STATUS);
    assign a_restart = clr_on_a && (count == cmp_a);

    // R2: free advance by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_ld && !a_restart) |=> (count == $past(count) + 16'd1));

    // R5: restart on channel A match
    p_restart_a_r5: assert property (@(posedge clk) disable iff (rst)
        (!cnt_ld && a_restart) |=> (count == '0));

    // R6: channel B alone never zeroes the counter
    p_b_no_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (!cnt_ld && (count == cmp_b) && (count != cmp_a) && (count != {CNT_W{1'b1}}))
        |=> (count != '0));

    // R7: wrap sets its flag
    p_wrap_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (!cnt_ld && !a_restart && (count == {CNT_W{1'b1}})) |=> flags[0]);

    // R8: without a status write no flag falls
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((flags & $past(flags)) == $past(flags)));

    // R10: vector is 0 when idle, else one of the three numbers
    p_vec_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_vector == V_NONE));
    p_vec_range_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((irq_vector == V_CHA) || (irq_vector == V_CHB) || (irq_vector == V_WRAP)));

endmodule

bind frc_timer frc_timer_checker u_frc_timer_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .irq        (irq),
    .irq_vector (irq_vector),
    .count      (count),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .clr_on_a   (clr_on_a),
    .flags      (flags)
);

// File: tb/frc_timer_bench.sv
module frc_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [7:0] irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frc_timer u_frc_timer (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .irq_vector (irq_vector)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] h;
        logic [7:0] l;
        rd(a, h);
        rd(a + 3'd1, l);
        v = {h, l};
    endtask

    // low byte first, then high byte: the high write edge does not advance
    task automatic set_counter(input logic [15:0] v);
        wr(3'd3, v[7:0]);
        wr(3'd2, v[15:8]);
    endtask

    task automatic set_cmp(input bit chan_b, input logic [15:0] v);
        wr(3'd7, chan_b ? 8'h10 : 8'h00);
        wr(3'd4, v[15:8]);
        wr(3'd5, v[7:0]);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  b;
        logic [15:0] w;
        logic [15:0] w0;
        logic [7:0]  lo0;

        tick(3);
        rst = 1'b0;

        // R1: reset values
        rd(3'd0, b);  chk("R1 enable", b, 8'h00);
        rd(3'd1, b);  chk("R1 status", b, 8'h00);
        rd16(3'd2, w); chk("R1 counter", w, 16'h0000);
        rd16(3'd4, w); chk("R1 match A", w, 16'hFFFF);
        rd(3'd7, b);  chk("R1 outctl", b, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 vector", irq_vector, 0);
        wr(3'd7, 8'h10);
        rd16(3'd4, w); chk("R1 match B", w, 16'hFFFF);
        wr(3'd7, 8'h00);

        // R2: free advance
        rd16(3'd2, w0);
        tick(37);
        rd16(3'd2, w);
        chk("R2 advance 37", w, 16'(w0 + 16'd37));
        tick(1);
        rd16(3'd2, w);
        chk("R2 advance 38", w, 16'(w0 + 16'd38));

        // R3: byte writes, no advance on the write edge
        rd(3'd3, lo0);
        wr(3'd2, 8'h12);
        rd16(3'd2, w); chk("R3 high byte load", w, {8'h12, lo0});
        wr(3'd3, 8'h34);
        rd16(3'd2, w); chk("R3 low byte load", w, 16'h1234);

        // R4: aliased match word
        set_cmp(1'b0, 16'h0100);
        set_cmp(1'b1, 16'h0200);
        rd16(3'd4, w); chk("R4 read B via select 1", w, 16'h0200);
        rd(3'd7, b);   chk("R4 select readback", b, 8'h10);
        wr(3'd7, 8'h00);
        rd16(3'd4, w); chk("R4 read A via select 0", w, 16'h0100);

        // R5: channel A match without restart
        wr(3'd1, 8'h00);
        set_counter(16'h00F0);
        tick(16);
        rd(3'd1, b);   chk("R5 flag not early", b, 8'h00);
        tick(1);
        rd(3'd1, b);   chk("R5 flag A set", b, 8'h08);
        rd16(3'd2, w); chk("R5 counter passes", w, 16'h0101);
        tick(5);
        rd(3'd1, b);   chk("R8 flag A held", b, 8'h08);

        // R5: with restart
        wr(3'd1, 8'h01);
        set_counter(16'h00F0);
        tick(17);
        rd16(3'd2, w); chk("R5 restart to zero", w, 16'h0000);
        rd(3'd1, b);   chk("R5 flag A with clear bit", b, 8'h09);

        // R6: channel B match, no restart
        wr(3'd1, 8'h00);
        set_counter(16'h01F0);
        tick(17);
        rd(3'd1, b);   chk("R6 flag B set", b, 8'h04);
        rd16(3'd2, w); chk("R6 counter not cleared", w, 16'h0201);

        // R7: wrap
        wr(3'd1, 8'h00);
        set_counter(16'hFFF0);
        tick(15);
        rd(3'd1, b);   chk("R7 no flag at 0xFFFF", b, 8'h00);
        rd16(3'd2, w); chk("R7 counter at top", w, 16'hFFFF);
        tick(1);
        rd(3'd1, b);   chk("R7 wrap flag", b, 8'h02);
        rd16(3'd2, w); chk("R7 counter wrapped", w, 16'h0000);

        // R7: restart at top does not count as wrap
        set_cmp(1'b0, 16'hFFFF);
        wr(3'd1, 8'h01);
        set_counter(16'hFFFE);
        tick(2);
        rd16(3'd2, w); chk("R7 restart at top", w, 16'h0000);
        rd(3'd1, b);   chk("R7 no wrap on restart", b, 8'h09);

        // R8: set wins over clear; writing 1 keeps
        set_cmp(1'b0, 16'h0100);
        wr(3'd1, 8'h00);
        set_counter(16'h00FF);
        tick(1);
        wr(3'd1, 8'h00);
        rd(3'd1, b);   chk("R8 set beats clear", b, 8'h08);
        wr(3'd1, 8'h0E);
        rd(3'd1, b);   chk("R8 write ones no effect", b, 8'h08);
        wr(3'd1, 8'h00);
        rd(3'd1, b);   chk("R8 write zero clears", b, 8'h00);

        // R9/R10: set all three flags, then sweep enables over flag states
        set_cmp(1'b0, 16'h0010);
        set_cmp(1'b1, 16'h0020);
        wr(3'd1, 8'h00);
        set_counter(16'hFFF0);
        tick(60);
        set_cmp(1'b0, 16'h8000);
        set_cmp(1'b1, 16'h9000);
        rd(3'd1, b);   chk("R9 all flags set", b, 8'h0E);
        for (int s = 0; s < 4; s++) begin
            logic [7:0] fl;
            case (s)
                0: fl = 8'h0E;
                1: fl = 8'h0C;
                2: fl = 8'h08;
                default: fl = 8'h00;
            endcase
            if (s != 0) wr(3'd1, fl);
            rd(3'd1, b);   chk("R8 flag state", b, fl);
            for (int e = 0; e < 8; e++) begin
                logic [7:0] en;
                logic [7:0] p;
                int exp_v;
                en = 8'(e << 1);
                wr(3'd0, en);
                p = en & fl;
                if (p[1])      exp_v = 18;
                else if (p[2]) exp_v = 17;
                else if (p[3]) exp_v = 16;
                else           exp_v = 0;
                #1;
                chk("R9 irq level", irq, int'(|p));
                chk("R10 vector", irq_vector, exp_v);
            end
        end

        // R11: unused bits and reserved address
        wr(3'd6, 8'hFF);
        rd(3'd6, b);   chk("R11 reserved reads 0", b, 8'h00);
        wr(3'd0, 8'hFF);
        rd(3'd0, b);   chk("R11 enable mask", b, 8'h0E);
        wr(3'd7, 8'hFF);
        rd(3'd7, b);   chk("R11 outctl mask", b, 8'h10);
        wr(3'd1, 8'hF0);
        rd(3'd1, b);   chk("R11 status mask", b, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule